// File: doc/BRIEF.md
# Snoop Request Response Controller

This controller serves coherence snoops that the interconnect sends to one write-back data cache. It takes one snoop at a time, made of a line address and a 4-bit snoop kind. It asks an external tag comparator for the flags of that line and waits for the answer. It then invalidates the line or marks it shared where the rules require it. Last, it returns a response. The response carries an error flag, a data-transfer flag, a dirty flag, a was-shared flag and, when data moves, the whole line.

The CPU-side controller may be rewriting a line. While it does so it raises `busy_i` with that line's address on `busy_addr_i`. A snoop to the same line waits in a hold state until the rewrite ends. Snoops to other lines go ahead at once.

Line flags are 3 bits: bit 2 valid, bit 1 dirty, bit 0 shared. The five line states are I = 000, UC = 100, UD = 110, SC = 101 and SD = 111. The supported snoop kinds are ReadOnce = 4'b0000, ReadShared = 4'b0001, ReadUnique = 4'b0111 and CleanInvalid = 4'b1001. Every other code is unsupported.

The FSM has these states:
- IDLE: the only state where `snp_ready_o` is high.
- HOLD: a snoop waits here while its line is busy.
- WAIT_TAG: `lk_req_o` stays high until `lk_rvalid_i`.
- INVAL: drives a one-cycle update to I.
- MK_SHARED: drives a one-cycle update that sets the shared bit.
- SEND_RSP: holds the response until `rsp_ready_i`.

The transitions are:
- IDLE→SEND_RSP: an unsupported kind is accepted.
- IDLE→HOLD: a busy line is accepted.
- IDLE→WAIT_TAG: any other accepted snoop.
- HOLD→WAIT_TAG: the busy condition clears.
- WAIT_TAG→INVAL, WAIT_TAG→MK_SHARED or WAIT_TAG→SEND_RSP: chosen by the decoded lookup result.
- INVAL→SEND_RSP and MK_SHARED→SEND_RSP.
- SEND_RSP→IDLE: the response handshake completes.

Top module: `snoop_resp_ctrl`

## Requirements
- R1: An unsupported kind (any code other than 0000, 0001, 0111, 1001) produces a response with `rsp_err_o`=1 and the data-transfer, dirty and shared bits 0. No lookup and no update are issued for it.
- R2: A supported snoop raises `lk_req_o` with the snoop address in the cycle after acceptance, unless it is held. No update or response is given while the lookup is pending.
- R3: ReadOnce (0000) hitting a valid line forwards the line data and issues no update.
- R4: ReadShared (0001) hitting a valid line issues one update that sets the shared bit and keeps the dirty bit (UC→SC, UD→SD, SC→SC, SD→SD). It then forwards the data.
- R5: ReadUnique (0111) hitting a valid line issues one update to I and forwards the data. The dirty bit reports the prior dirtiness.
- R6: CleanInvalid (1001) hitting a valid line issues one update to I. It forwards data only when the line was dirty (UD or SD).
- R7: A supported snoop to an invalid line gives a response without data, with the error, dirty and shared bits all 0, and issues no update.
- R8: While `busy_i` is high and `busy_addr_i` equals the snoop line, no lookup is issued. The lookup starts in the cycle after `busy_i` falls. A busy signal for another line causes no delay.
- R9: All response flags and the data appear in the same cycle as `rsp_valid_o`. They stay stable while `rsp_ready_i` is low. `rsp_dirty_o` is 1 only when data is transferred and the prior state was UD or SD. `rsp_shared_o` is the prior shared bit of a valid line.
- R10: The controller returns to IDLE, and raises `snp_ready_o` again, only in the cycle after the response handshake. `snp_ready_o` is never high while a response is pending.
- R11: After reset, `snp_ready_o`=1 and `lk_req_o`, `upd_valid_o` and `rsp_valid_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| snp_valid_i | input | 1 | Snoop request valid |
| snp_ready_o | output | 1 | Snoop request accepted (high in IDLE) |
| snp_addr_i | input | AW | Snoop line address |
| snp_kind_i | input | 4 | Snoop kind code |
| lk_req_o | output | 1 | Tag/flag lookup request |
| lk_addr_o | output | AW | Lookup line address |
| lk_rvalid_i | input | 1 | Lookup result valid |
| lk_hit_i | input | 1 | Tag match |
| lk_flags_i | input | 3 | Line flags {valid, dirty, shared} |
| lk_data_i | input | LW | Line data |
| busy_i | input | 1 | Another controller is updating a line |
| busy_addr_i | input | AW | Line being updated |
| upd_valid_o | output | 1 | Line state update strobe |
| upd_addr_o | output | AW | Line to update |
| upd_flags_o | output | 3 | New line flags |
| rsp_valid_o | output | 1 | Snoop response valid |
| rsp_ready_i | input | 1 | Snoop response accepted |
| rsp_err_o | output | 1 | Unsupported snoop |
| rsp_xfer_o | output | 1 | Response carries line data |
| rsp_dirty_o | output | 1 | Forwarded line was dirty |
| rsp_shared_o | output | 1 | Line was shared |
| rsp_data_o | output | LW | Line data (zero without transfer) |

## Verification
Some behaviours are checked by the assertions on every cycle:
- no lookup follows a busy-line acceptance;
- response fields stay frozen under backpressure;
- error responses never carry data or flags;
- dirty implies transfer;
- lookup, update and response never overlap;
- updates never leave a line valid and unique.

The bench sweeps all sixteen kind codes against all five line states. That sweep is the only way to show the actual per-kind state transitions and the data-forwarding choices. The cycle counts of the hold and of the return to IDLE can also be shown only by the bench's scenarios.

// File: rtl/snp_pkg.sv
package snp_pkg;

    typedef struct packed {
        logic valid;
        logic dirty;
        logic shared;
    } line_flags_t;

    localparam logic [3:0] KIND_RD_ONCE   = 4'b0000;
    localparam logic [3:0] KIND_RD_SHARED = 4'b0001;
    localparam logic [3:0] KIND_RD_UNIQUE = 4'b0111;
    localparam logic [3:0] KIND_CLN_INV   = 4'b1001;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HOLD,
        ST_WAIT_TAG,
        ST_INVAL,
        ST_MK_SHARED,
        ST_SEND_RSP
    } snp_state_t;

    function automatic logic kind_supported(input logic [3:0] k);
        return (k == KIND_RD_ONCE) || (k == KIND_RD_SHARED) ||
               (k == KIND_RD_UNIQUE) || (k == KIND_CLN_INV);
    endfunction

endpackage

// File: rtl/snp_decode.sv
module snp_decode
    import snp_pkg::*;
(
    input  logic [3:0]  kind_i,
    input  line_flags_t flags_i,
    output logic        supported_o,
    output logic        fwd_o,
    output logic        to_shared_o,
    output logic        to_inval_o,
    output line_flags_t new_flags_o,
    output logic        rsp_dirty_o,
    output logic        rsp_shared_o
);
    logic hit;

    always_comb begin
        supported_o  = kind_supported(kind_i);
        hit          = supported_o && flags_i.valid;
        fwd_o        = 1'b0;
        to_shared_o  = 1'b0;
        to_inval_o   = 1'b0;
        new_flags_o  = flags_i;
        unique case (kind_i)
            KIND_RD_ONCE: begin
                fwd_o = hit;
            end
            KIND_RD_SHARED: begin
                fwd_o       = hit;
                to_shared_o = hit;
                new_flags_o = '{valid: 1'b1, dirty: flags_i.dirty, shared: 1'b1};
            end
            KIND_RD_UNIQUE: begin
                fwd_o       = hit;
                to_inval_o  = hit;
                new_flags_o = '0;
            end
            KIND_CLN_INV: begin
                fwd_o       = hit && flags_i.dirty;
                to_inval_o  = hit;
                new_flags_o = '0;
            end
            default: begin
                fwd_o = 1'b0;
            end
        endcase
        rsp_dirty_o  = fwd_o && flags_i.dirty;
        rsp_shared_o = hit && flags_i.shared;
    end

endmodule

// File: rtl/snp_line_guard.sv
module snp_line_guard #(
    parameter int AW = 8
) (
    input  logic          busy_i,
    input  logic [AW-1:0] busy_addr_i,
    input  logic [AW-1:0] addr_i,
    output logic          stall_o
);
    always_comb begin
        stall_o = busy_i && (busy_addr_i == addr_i);
    end
endmodule

// File: rtl/snoop_resp_ctrl.sv
module snoop_resp_ctrl
    import snp_pkg::*;
#(
    parameter int AW = 8,
    parameter int LW = 64
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          snp_valid_i,
    output logic          snp_ready_o,
    input  logic [AW-1:0] snp_addr_i,
    input  logic [3:0]    snp_kind_i,
    output logic          lk_req_o,
    output logic [AW-1:0] lk_addr_o,
    input  logic          lk_rvalid_i,
    input  logic          lk_hit_i,
    input  logic [2:0]    lk_flags_i,
    input  logic [LW-1:0] lk_data_i,
    input  logic          busy_i,
    input  logic [AW-1:0] busy_addr_i,
    output logic          upd_valid_o,
    output logic [AW-1:0] upd_addr_o,
    output logic [2:0]    upd_flags_o,
    output logic          rsp_valid_o,
    input  logic          rsp_ready_i,
    output logic          rsp_err_o,
    output logic          rsp_xfer_o,
    output logic          rsp_dirty_o,
    output logic          rsp_shared_o,
    output logic [LW-1:0] rsp_data_o
);
    snp_state_t    state_q, state_d;
    logic [AW-1:0] addr_q;
    logic [3:0]    kind_q;
    line_flags_t   flags_q;
    logic [LW-1:0] data_q;

    logic          accept;
    logic          stall;
    logic [AW-1:0] guard_addr;
    line_flags_t   dec_flags;
    line_flags_t   lk_flags;
    line_flags_t   new_flags;
    logic          dec_sup, dec_fwd, dec_to_shared, dec_to_inval;
    logic          dec_dirty, dec_shared;

    assign lk_flags   = line_flags_t'(lk_flags_i);
    assign accept     = snp_valid_i && (state_q == ST_IDLE);
    assign guard_addr = (state_q == ST_IDLE) ? snp_addr_i : addr_q;
    assign dec_flags  = (state_q == ST_WAIT_TAG) ? (lk_hit_i ? lk_flags : '0) : flags_q;

    snp_line_guard #(.AW(AW)) i_guard (
        .busy_i      (busy_i),
        .busy_addr_i (busy_addr_i),
        .addr_i      (guard_addr),
        .stall_o     (stall)
    );

    snp_decode i_decode (
        .kind_i       (kind_q),
        .flags_i      (dec_flags),
        .supported_o  (dec_sup),
        .fwd_o        (dec_fwd),
        .to_shared_o  (dec_to_shared),
        .to_inval_o   (dec_to_inval),
        .new_flags_o  (new_flags),
        .rsp_dirty_o  (dec_dirty),
        .rsp_shared_o (dec_shared)
    );

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (snp_valid_i) begin
                    if (!kind_supported(snp_kind_i)) state_d = ST_SEND_RSP;
                    else if (stall)                  state_d = ST_HOLD;
                    else                             state_d = ST_WAIT_TAG;
                end
            end
            ST_HOLD: begin
                if (!stall) state_d = ST_WAIT_TAG;
            end
            ST_WAIT_TAG: begin
                if (lk_rvalid_i) begin
                    if (dec_to_inval)       state_d = ST_INVAL;
                    else if (dec_to_shared) state_d = ST_MK_SHARED;
                    else                    state_d = ST_SEND_RSP;
                end
            end
            ST_INVAL:     state_d = ST_SEND_RSP;
            ST_MK_SHARED: state_d = ST_SEND_RSP;
            ST_SEND_RSP: begin
                if (rsp_ready_i) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state and capture registers
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= ST_IDLE;
            addr_q  <= '0;
            kind_q  <= '0;
            flags_q <= '0;
            data_q  <= '0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                addr_q  <= snp_addr_i;
                kind_q  <= snp_kind_i;
                flags_q <= '0;
                data_q  <= '0;
            end else if (state_q == ST_WAIT_TAG && lk_rvalid_i) begin
                flags_q <= lk_hit_i ? lk_flags : '0;
                data_q  <= lk_data_i;
            end
        end
    end

    // outputs
    always_comb begin
        snp_ready_o  = 1'b0;
        lk_req_o     = 1'b0;
        lk_addr_o    = addr_q;
        upd_valid_o  = 1'b0;
        upd_addr_o   = addr_q;
        upd_flags_o  = new_flags;
        rsp_valid_o  = 1'b0;
        rsp_err_o    = 1'b0;
        rsp_xfer_o   = 1'b0;
        rsp_dirty_o  = 1'b0;
        rsp_shared_o = 1'b0;
        rsp_data_o   = '0;
        unique case (state_q)
            ST_IDLE:      snp_ready_o = 1'b1;
            ST_HOLD:      ;
            ST_WAIT_TAG:  lk_req_o = 1'b1;
            ST_INVAL:     upd_valid_o = 1'b1;
            ST_MK_SHARED: upd_valid_o = 1'b1;
            ST_SEND_RSP: begin
                rsp_valid_o  = 1'b1;
                rsp_err_o    = !dec_sup;
                rsp_xfer_o   = dec_fwd;
                rsp_dirty_o  = dec_dirty;
                rsp_shared_o = dec_shared;
                rsp_data_o   = dec_fwd ? data_q : '0;
            end
            default: ;
        endcase
    end

    // R1
    err_clean_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rsp_err_o |-> (!rsp_xfer_o && !rsp_dirty_o && !rsp_shared_o));

    // R2
    lookup_exclusive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        lk_req_o |-> (!rsp_valid_o && !upd_valid_o && !snp_ready_o));

    // R4
    upd_never_unique_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        upd_valid_o |-> (!upd_flags_o[2] || upd_flags_o[0]));

    // R8
    busy_no_lookup_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (snp_valid_i && snp_ready_o && busy_i && busy_addr_i == snp_addr_i) |=> !lk_req_o);

    // R9
    rsp_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rsp_valid_o && !rsp_ready_i) |=> (rsp_valid_o &&
            $stable({rsp_err_o, rsp_xfer_o, rsp_dirty_o, rsp_shared_o, rsp_data_o})));

    // R9
    dirty_needs_xfer_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rsp_dirty_o |-> rsp_xfer_o);

    // R10
    ready_idle_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rsp_valid_o |-> !snp_ready_o);

    // R10
    return_after_hs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rsp_valid_o && rsp_ready_i) |=> (snp_ready_o && !rsp_valid_o));

endmodule

// File: tb/test_snoop_resp_ctrl.sv
`timescale 1ns/1ps
module test_snoop_resp_ctrl;
    localparam int AW = 8;
    localparam int LW = 64;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          snp_valid = 1'b0;
    logic          snp_ready;
    logic [AW-1:0] snp_addr = '0;
    logic [3:0]    snp_kind = '0;
    logic          lk_req;
    logic [AW-1:0] lk_addr;
    logic          lk_rvalid = 1'b0;
    logic          lk_hit = 1'b0;
    logic [2:0]    lk_flags = '0;
    logic [LW-1:0] lk_data = '0;
    logic          busy = 1'b0;
    logic [AW-1:0] busy_addr = '0;
    logic          upd_valid;
    logic [AW-1:0] upd_addr;
    logic [2:0]    upd_flags;
    logic          rsp_valid;
    logic          rsp_ready = 1'b0;
    logic          rsp_err, rsp_xfer, rsp_dirty, rsp_shared;
    logic [LW-1:0] rsp_data;

    int n_checks = 0;
    int n_fail   = 0;
    logic [2:0] model [8];

    always #2 clk = ~clk;

    snoop_resp_ctrl #(.AW(AW), .LW(LW)) i_snoop_resp_ctrl (
        .clk_i(clk), .rst_ni(rst_n),
        .snp_valid_i(snp_valid), .snp_ready_o(snp_ready),
        .snp_addr_i(snp_addr), .snp_kind_i(snp_kind),
        .lk_req_o(lk_req), .lk_addr_o(lk_addr), .lk_rvalid_i(lk_rvalid),
        .lk_hit_i(lk_hit), .lk_flags_i(lk_flags), .lk_data_i(lk_data),
        .busy_i(busy), .busy_addr_i(busy_addr),
        .upd_valid_o(upd_valid), .upd_addr_o(upd_addr), .upd_flags_o(upd_flags),
        .rsp_valid_o(rsp_valid), .rsp_ready_i(rsp_ready),
        .rsp_err_o(rsp_err), .rsp_xfer_o(rsp_xfer), .rsp_dirty_o(rsp_dirty),
        .rsp_shared_o(rsp_shared), .rsp_data_o(rsp_data)
    );

    task automatic check(input logic ok, input string req, input logic [LW-1:0] act,
                         input logic [LW-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [LW-1:0] line_data(input logic [AW-1:0] a);
        return {8{a ^ 8'hA5}};
    endfunction

    // hold: cycles the line stays busy after acceptance; other: busy on a different line
    task automatic snoop(input logic [3:0] k, input logic [2:0] st, input logic [AW-1:0] a,
                         input int hold, input logic other);
        logic sup, hit, dty, shd, xfer, upd_exp;
        logic [2:0] nst;
        string tag;
        sup = (k == 4'b0000) || (k == 4'b0001) || (k == 4'b0111) || (k == 4'b1001);
        hit = sup && st[2];
        dty = st[1];
        shd = st[0];
        xfer = hit && (k != 4'b1001 || dty);
        upd_exp = hit && (k != 4'b0000);
        nst = st;
        if (hit && k == 4'b0001) nst = {1'b1, dty, 1'b1};
        if (hit && (k == 4'b0111 || k == 4'b1001)) nst = 3'b000;
        case (k)
            4'b0000: tag = "R3";
            4'b0001: tag = "R4";
            4'b0111: tag = "R5";
            4'b1001: tag = "R6";
            default: tag = "R1";
        endcase
        if (sup && !hit) tag = "R7";
        model[a[2:0]] = st;

        @(negedge clk);
        busy      = (hold > 0) || other;
        busy_addr = (hold > 0) ? a : a ^ 8'h01;
        snp_valid = 1'b1; snp_kind = k; snp_addr = a;
        check(snp_ready === 1'b1, "R10 ready in idle", snp_ready, 1);
        @(negedge clk);
        snp_valid = 1'b0;
        if (!sup) begin
            check(lk_req === 1'b0, "R1 no lookup", lk_req, 0);
        end else begin
            for (int i = 0; i < hold; i++) begin
                check(lk_req === 1'b0, "R8 held while busy", lk_req, 0);
                if (i == hold - 1) busy = 1'b0;
                @(negedge clk);
            end
            busy = 1'b0;
            check(lk_req === 1'b1 && lk_addr === a, "R2 lookup issued", {lk_req, lk_addr},
                  {1'b1, a});
            lk_rvalid = 1'b1; lk_hit = st[2]; lk_flags = st; lk_data = line_data(a);
            @(negedge clk);
            lk_rvalid = 1'b0; lk_hit = 1'b0; lk_flags = '0; lk_data = '0;
            if (upd_exp) begin
                check(upd_valid === 1'b1 && upd_addr === a && upd_flags === nst,
                      {tag, " update"}, {upd_valid, upd_flags}, {1'b1, nst});
                model[a[2:0]] = upd_flags;
                @(negedge clk);
            end else begin
                check(upd_valid === 1'b0, {tag, " no update"}, upd_valid, 0);
            end
        end
        busy = 1'b0;
        for (int r = 0; r < 2; r++) begin
            check(rsp_valid === 1'b1 && rsp_err === !sup && rsp_xfer === xfer &&
                  rsp_dirty === (xfer && dty) && rsp_shared === (hit && shd),
                  {tag, " R9 rsp flags"}, {rsp_valid, rsp_err, rsp_xfer, rsp_dirty, rsp_shared},
                  {1'b1, !sup, xfer, xfer && dty, hit && shd});
            check(rsp_data === (xfer ? line_data(a) : '0), {tag, " rsp data"}, rsp_data,
                  xfer ? line_data(a) : '0);
            check(snp_ready === 1'b0, "R10 not ready while rsp pending", snp_ready, 0);
            if (r == 1) rsp_ready = 1'b1;
            @(negedge clk);
        end
        rsp_ready = 1'b0;
        check(snp_ready === 1'b1 && rsp_valid === 1'b0, "R10 back to idle",
              {snp_ready, rsp_valid}, 2'b10);
        check(model[a[2:0]] === nst, {tag, " final line state"}, model[a[2:0]], nst);
    endtask

    initial begin
        logic [2:0] states [5];
        states[0] = 3'b000; states[1] = 3'b100; states[2] = 3'b110;
        states[3] = 3'b101; states[4] = 3'b111;
        repeat (3) @(negedge clk);
        check(snp_ready === 1'b1 && lk_req === 1'b0 && upd_valid === 1'b0 &&
              rsp_valid === 1'b0, "R11 reset state",
              {snp_ready, lk_req, upd_valid, rsp_valid}, 4'b1000);
        rst_n = 1'b1;
        for (int k = 0; k < 16; k++) begin
            for (int s = 0; s < 5; s++) begin
                snoop(4'(k), states[s], 8'(k * 5 + s), 0, 1'b0);
            end
        end
        // R8: same-line busy holds, other-line busy does not
        snoop(4'b0001, 3'b110, 8'h21, 1, 1'b0);
        snoop(4'b0111, 3'b101, 8'h32, 4, 1'b0);
        snoop(4'b1001, 3'b111, 8'h43, 3, 1'b0);
        snoop(4'b0000, 3'b100, 8'h54, 0, 1'b1);
        snoop(4'b0111, 3'b110, 8'h65, 0, 1'b1);
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule